// File: doc/BRIEF.md
# Command Byte Stream Framer

This block sits at the front of a serial-engine controller. It takes one continuous stream of command bytes on a valid/ready input and finds where each command begins and ends. The first byte of each command is an opcode. The block classifies it as a shift, port, bus-cycle or control command and works out how many argument bytes follow. It collects those bytes and presents the whole command, once, on a held header interface. Downstream units take the header and do the actual work: the shift engine, the two GPIO port registers and the bus-cycle unit.

Shift commands that drive data out in byte mode carry an embedded little-endian count. After the header has been taken, the block forwards the count-plus-one data bytes as a pass-through stream, so no payload storage is needed. Bytes that are not a defined opcode produce a one-cycle error strobe that carries the offending byte, and parsing resumes at the next byte. Gaps in the input stream and backpressure from any consumer leave the framing intact.

Top module: `opstrm_parser`

## Requirements
- R1: After reset, in_ready is 1 and cmd_valid, pay_valid and err_valid are 0.
- R2: An opcode with bit 7 clear and bit 1 clear is a byte-mode shift. It takes 2 argument bytes, low byte first. The header shows cmd_kind 0, cmd_nparam 2 and cmd_count = {second byte, first byte}.
- R3: A byte-mode shift with opcode bit 4 set is followed, after the header handshake, by cmd_count+1 payload bytes on the pay_* stream. pay_last is 1 only on the final byte, and the byte after it is parsed as an opcode. A byte-mode shift with bit 4 clear has no payload.
- R4: An opcode with bit 7 clear and bit 1 set is a bit-mode shift. It takes 2 argument bytes when bit 4 or bit 6 is set, and 1 otherwise. cmd_count equals the first argument byte.
- R5: Opcodes 0x80 and 0x82 give cmd_kind 1 and cmd_nparam 2, with the pin value in cmd_arg[7:0] and the direction mask (1 = output) in cmd_arg[15:8]. Opcodes 0x81 and 0x83 give cmd_kind 1 and cmd_nparam 0.
- R6: Opcodes 0x90, 0x91, 0x92 and 0x93 give cmd_kind 2 with cmd_nparam 1, 2, 2 and 3. Opcode bit 0 selects a 2-byte big-endian address; otherwise the 1-byte address is zero-extended. The result appears on cmd_addr. A write (bit 1 set) carries its data in the last argument byte.
- R7: Opcodes 0x86, 0x8F, 0x9C, 0x9D and 0x9E take 2 arguments, and 0x8E takes 1. Opcodes 0x84, 0x85, 0x87 to 0x8D and 0x94 to 0x97 take none. All of these give cmd_kind 3.
- R8: A byte outside the defined opcode set raises err_valid for one cycle, in the cycle after it is accepted, with err_byte equal to that byte. It produces no command, and the next byte is parsed as an opcode. Undefined values include 0x00 and 0x9F.
- R9: Idle cycles on in_valid at any point inside a command do not change the command produced.
- R10: While cmd_valid is 1 and cmd_ready is 0, in_ready is 0 and all header outputs hold their values.
- R11: During payload, in_ready equals pay_ready, pay_data equals in_data, and pay_valid is 0 while a header is pending. Argument byte k always sits in cmd_arg[8k+7:8k], and unused bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| cmd_valid | output | 1 | Framed command header available |
| cmd_ready | input | 1 | Downstream takes the header |
| cmd_opcode | output | 8 | Opcode of the command |
| cmd_kind | output | 2 | 0 shift, 1 port, 2 bus cycle, 3 control |
| cmd_nparam | output | 2 | Number of argument bytes collected |
| cmd_arg | output | 24 | Argument bytes in arrival order, byte k at bits 8k+7:8k |
| cmd_count | output | 16 | Shift count field (CNT_W bits) |
| cmd_addr | output | 16 | Bus-cycle address |
| pay_valid | output | 1 | Payload byte valid |
| pay_ready | input | 1 | Shift engine takes the payload byte |
| pay_data | output | 8 | Payload byte |
| pay_last | output | 1 | Final payload byte of the command |
| err_valid | output | 1 | Undefined opcode strobe |
| err_byte | output | 8 | Offending byte |

## Verification
The bench builds the block with the default 16-bit count width. This lets it present the full little-endian count field (0x1234) and confirm byte ordering on the header. Payload runs use small counts (0 to 2) so that the pay_last position and the return to opcode parsing can be checked byte by byte. With the 3-byte argument limit, the longest bus-cycle write and every shorter argument length can be reached, including stalls on cmd_ready and pay_ready in the middle of a command.

// File: rtl/opstrm_pkg.sv
package opstrm_pkg;
  localparam int OPC_W     = 8;
  localparam int MAX_PARAM = 3;
  localparam int NP_W      = $clog2(MAX_PARAM + 1);
  localparam int ARG_W     = MAX_PARAM * OPC_W;
  localparam int ADDR_W    = 2 * OPC_W;

  typedef enum logic [1:0] {
    K_SHIFT = 2'd0,
    K_PORT  = 2'd1,
    K_BUS   = 2'd2,
    K_CTRL  = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    logic            legal;
    cmd_kind_e       kind;
    logic [NP_W-1:0] nparam;
    logic            payload;
  } op_info_t;
endpackage

// File: rtl/opstrm_decode.sv
module opstrm_decode
  import opstrm_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output op_info_t         info
);
  always_comb begin
    info        = '0;
    info.kind   = K_CTRL;
    if (!opc[7]) begin
      info.kind = K_SHIFT;
      case (opc)
        8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h19, 8'h1A, 8'h1B,
        8'h20, 8'h22, 8'h24, 8'h26, 8'h28, 8'h2A, 8'h2C, 8'h2E,
        8'h31, 8'h33, 8'h34, 8'h36, 8'h39, 8'h3B, 8'h3C, 8'h3E,
        8'h4A, 8'h4B, 8'h6A, 8'h6B, 8'h6E, 8'h6F: info.legal = 1'b1;
        default:                                  info.legal = 1'b0;
      endcase
      if (!opc[1]) begin
        info.nparam  = NP_W'(2);
        info.payload = opc[4];
      end else begin
        info.nparam  = (opc[4] || opc[6]) ? NP_W'(2) : NP_W'(1);
      end
    end else begin
      case (opc)
        8'h80, 8'h82: begin info.legal = 1'b1; info.kind = K_PORT; info.nparam = NP_W'(2); end
        8'h81, 8'h83: begin info.legal = 1'b1; info.kind = K_PORT; end
        8'h90:        begin info.legal = 1'b1; info.kind = K_BUS;  info.nparam = NP_W'(1); end
        8'h91, 8'h92: begin info.legal = 1'b1; info.kind = K_BUS;  info.nparam = NP_W'(2); end
        8'h93:        begin info.legal = 1'b1; info.kind = K_BUS;  info.nparam = NP_W'(3); end
        8'h86, 8'h8F, 8'h9C, 8'h9D, 8'h9E:
                      begin info.legal = 1'b1; info.nparam = NP_W'(2); end
        8'h8E:        begin info.legal = 1'b1; info.nparam = NP_W'(1); end
        8'h84, 8'h85, 8'h87, 8'h88, 8'h89, 8'h8A, 8'h8B, 8'h8C, 8'h8D,
        8'h94, 8'h95, 8'h96, 8'h97:
                      info.legal = 1'b1;
        default:      info.legal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/opstrm_framer.sv
module opstrm_framer
  import opstrm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  in_data,
  output logic              in_ready,
  input  op_info_t          info,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [OPC_W-1:0]  cmd_opcode,
  output logic [1:0]        cmd_kind,
  output logic [NP_W-1:0]   cmd_nparam,
  output logic [ARG_W-1:0]  cmd_arg,
  output logic [CNT_W-1:0]  cmd_count,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              pay_valid,
  input  logic              pay_ready,
  output logic [OPC_W-1:0]  pay_data,
  output logic              pay_last,
  output logic              err_valid,
  output logic [OPC_W-1:0]  err_byte
);
  typedef enum logic [1:0] {S_OPC, S_PARM, S_ISSUE, S_PAY} st_e;

  st_e                              state_q, state_d;
  logic [OPC_W-1:0]                 opc_q;
  cmd_kind_e                        kind_q;
  logic [NP_W-1:0]                  np_q, idx_q, idx_d;
  logic                             pl_q;
  logic [MAX_PARAM-1:0][OPC_W-1:0]  arg_q, arg_d;
  logic [CNT_W-1:0]                 rem_q, rem_d, cnt_w;
  logic                             err_v_d, err_v_q;
  logic [OPC_W-1:0]                 err_b_q;
  logic                             hdr_en, arg_en, rem_en, err_en;

  assign in_ready = (state_q == S_OPC) || (state_q == S_PARM) ||
                    ((state_q == S_PAY) && pay_ready);

  // count field: bit mode uses one byte, byte mode a little-endian pair
  always_comb begin
    if (opc_q[1]) cnt_w = CNT_W'(arg_q[0]);
    else          cnt_w = CNT_W'({arg_q[1], arg_q[0]});
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    arg_d   = arg_q;
    rem_d   = rem_q;
    err_v_d = 1'b0;
    hdr_en  = 1'b0;
    arg_en  = 1'b0;
    rem_en  = 1'b0;
    err_en  = 1'b0;
    case (state_q)
      S_OPC: if (in_valid) begin
        if (!info.legal) begin
          err_v_d = 1'b1;
          err_en  = 1'b1;
        end else begin
          hdr_en  = 1'b1;
          arg_en  = 1'b1;
          arg_d   = '0;
          idx_d   = '0;
          state_d = (info.nparam == '0) ? S_ISSUE : S_PARM;
        end
      end
      S_PARM: if (in_valid) begin
        arg_en        = 1'b1;
        arg_d[idx_q]  = in_data;
        idx_d         = idx_q + NP_W'(1);
        if (idx_q == np_q - NP_W'(1)) state_d = S_ISSUE;
      end
      S_ISSUE: if (cmd_ready) begin
        if (pl_q) begin
          state_d = S_PAY;
          rem_en  = 1'b1;
          rem_d   = cnt_w;
        end else begin
          state_d = S_OPC;
        end
      end
      S_PAY: if (in_valid && pay_ready) begin
        if (rem_q == '0) begin
          state_d = S_OPC;
        end else begin
          rem_en = 1'b1;
          rem_d  = rem_q - CNT_W'(1);
        end
      end
      default: state_d = S_OPC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OPC;
      opc_q   <= '0;
      kind_q  <= K_SHIFT;
      np_q    <= '0;
      pl_q    <= 1'b0;
      idx_q   <= '0;
      arg_q   <= '0;
      rem_q   <= '0;
      err_v_q <= 1'b0;
      err_b_q <= '0;
    end else begin
      state_q <= state_d;
      err_v_q <= err_v_d;
      idx_q   <= idx_d;
      if (hdr_en) begin
        opc_q  <= in_data;
        kind_q <= info.kind;
        np_q   <= info.nparam;
        pl_q   <= info.payload;
      end
      if (arg_en) arg_q   <= arg_d;
      if (rem_en) rem_q   <= rem_d;
      if (err_en) err_b_q <= in_data;
    end
  end

  assign cmd_valid  = (state_q == S_ISSUE);
  assign cmd_opcode = opc_q;
  assign cmd_kind   = kind_q;
  assign cmd_nparam = np_q;
  assign cmd_arg    = arg_q;
  assign cmd_count  = cnt_w;
  assign cmd_addr   = opc_q[0] ? {arg_q[0], arg_q[1]} : {{OPC_W{1'b0}}, arg_q[0]};
  assign pay_valid  = (state_q == S_PAY) && in_valid;
  assign pay_data   = in_data;
  assign pay_last   = (rem_q == '0);
  assign err_valid  = err_v_q;
  assign err_byte   = err_b_q;
endmodule

// File: rtl/opstrm_parser.sv
module opstrm_parser
  import opstrm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_opcode,
  output logic [1:0]        cmd_kind,
  output logic [1:0]        cmd_nparam,
  output logic [23:0]       cmd_arg,
  output logic [CNT_W-1:0]  cmd_count,
  output logic [15:0]       cmd_addr,
  output logic              pay_valid,
  input  logic              pay_ready,
  output logic [7:0]        pay_data,
  output logic              pay_last,
  output logic              err_valid,
  output logic [7:0]        err_byte
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;
  op_info_t          dec_info;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  opstrm_decode u_dec (
    .opc  (in_data),
    .info (dec_info)
  );

  opstrm_framer #(.CNT_W(CNT_W)) u_frm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .info       (dec_info),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_opcode (cmd_opcode),
    .cmd_kind   (cmd_kind),
    .cmd_nparam (cmd_nparam),
    .cmd_arg    (cmd_arg),
    .cmd_count  (cmd_count),
    .cmd_addr   (cmd_addr),
    .pay_valid  (pay_valid),
    .pay_ready  (pay_ready),
    .pay_data   (pay_data),
    .pay_last   (pay_last),
    .err_valid  (err_valid),
    .err_byte   (err_byte)
  );
endmodule

// File: rtl/opstrm_parser_chk.sv
module opstrm_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_opcode,
  input logic [23:0] cmd_arg,
  input logic        pay_valid,
  input logic        pay_ready,
  input logic        pay_last,
  input logic        err_valid
);
  // R10
  hdr_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !in_ready);

  // R10
  hdr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_opcode) && $stable(cmd_arg)));

  // R11
  no_pay_before_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !pay_valid);

  // R3
  last_ends_pay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && pay_ready && pay_last) |=> !pay_valid);

  // R8
  err_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> $past(in_valid && in_ready));
endmodule

bind opstrm_parser opstrm_parser_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_opcode (cmd_opcode),
  .cmd_arg    (cmd_arg),
  .pay_valid  (pay_valid),
  .pay_ready  (pay_ready),
  .pay_last   (pay_last),
  .err_valid  (err_valid)
);

// File: tb/opstrm_parser_tb.sv
`timescale 1ns/1ps
module opstrm_parser_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [7:0]  cmd_opcode;
  logic [1:0]  cmd_kind;
  logic [1:0]  cmd_nparam;
  logic [23:0] cmd_arg;
  logic [15:0] cmd_count;
  logic [15:0] cmd_addr;
  logic        pay_valid;
  logic        pay_ready = 1'b1;
  logic [7:0]  pay_data;
  logic        pay_last;
  logic        err_valid;
  logic [7:0]  err_byte;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  opstrm_parser #(.CNT_W(16)) u_dut (.*);

  // captured traffic
  int          ncmd = 0, npay = 0, nerr = 0;
  logic [7:0]  c_opc;
  logic [1:0]  c_kind, c_np;
  logic [23:0] c_arg;
  logic [15:0] c_cnt, c_addr;
  logic [7:0]  e_byte;
  logic [7:0]  pbuf [0:15];
  logic        plast [0:15];

  always @(negedge clk) begin
    if (cmd_valid && cmd_ready) begin
      ncmd++; c_opc = cmd_opcode; c_kind = cmd_kind; c_np = cmd_nparam;
      c_arg = cmd_arg; c_cnt = cmd_count; c_addr = cmd_addr;
    end
    if (pay_valid && pay_ready && npay < 16) begin
      pbuf[npay] = pay_data; plast[npay] = pay_last; npay++;
    end
    if (err_valid) begin nerr++; e_byte = err_byte; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chkeq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chkeq("R1 in_ready", in_ready, 1);
    chkeq("R1 cmd_valid", cmd_valid, 0);
    chkeq("R1 pay_valid", pay_valid, 0);
    chkeq("R1 err_valid", err_valid, 0);
  endtask

  task automatic t_ctrl;
    int c0 = ncmd;
    send(8'h87); idle(3);
    chkeq("R7 0x87 count", ncmd - c0, 1);
    chkeq("R7 0x87 kind", c_kind, 3);
    chkeq("R7 0x87 nparam", c_np, 0);
    send(8'h86); send(8'h11); send(8'h22); idle(3);
    chkeq("R7 0x86 nparam", c_np, 2);
    chkeq("R11 0x86 arg", c_arg, 24'h002211);
    send(8'h8E); send(8'h09); idle(3);
    chkeq("R7 0x8E nparam", c_np, 1);
    chkeq("R7 0x8E opcode", c_opc, 8'h8E);
  endtask

  task automatic t_port;
    send(8'h80); send(8'hA5); send(8'h0F); idle(3);
    chkeq("R5 0x80 kind", c_kind, 1);
    chkeq("R5 0x80 nparam", c_np, 2);
    chkeq("R5 value byte", c_arg[7:0], 8'hA5);
    chkeq("R5 direction byte", c_arg[15:8], 8'h0F);
    send(8'h81); idle(3);
    chkeq("R5 0x81 kind", c_kind, 1);
    chkeq("R5 0x81 nparam", c_np, 0);
  endtask

  task automatic t_bus;
    send(8'h93); send(8'h12); send(8'h34); send(8'h56); idle(3);
    chkeq("R6 0x93 kind", c_kind, 2);
    chkeq("R6 0x93 nparam", c_np, 3);
    chkeq("R6 0x93 addr", c_addr, 16'h1234);
    chkeq("R6 0x93 data", c_arg[23:16], 8'h56);
    send(8'h90); send(8'h7E); idle(3);
    chkeq("R6 0x90 nparam", c_np, 1);
    chkeq("R6 0x90 addr", c_addr, 16'h007E);
    send(8'h91); send(8'hAB); send(8'hCD); idle(3);
    chkeq("R6 0x91 addr", c_addr, 16'hABCD);
    send(8'h92); send(8'h05); send(8'h77); idle(3);
    chkeq("R6 0x92 nparam", c_np, 2);
    chkeq("R6 0x92 addr", c_addr, 16'h0005);
  endtask

  task automatic t_shift_write;
    int p0 = npay;
    send(8'h19); send(8'h02); send(8'h00); idle(2);
    chkeq("R2 0x19 kind", c_kind, 0);
    chkeq("R2 0x19 count", c_cnt, 16'h0002);
    send(8'hC1); send(8'hC2); send(8'hC3); idle(2);
    chkeq("R3 payload bytes", npay - p0, 3);
    chkeq("R3 byte0", pbuf[p0], 8'hC1);
    chkeq("R3 byte2", pbuf[p0+2], 8'hC3);
    chkeq("R3 last only at end", {plast[p0], plast[p0+1], plast[p0+2]}, 3'b001);
    send(8'h87); idle(3);
    chkeq("R3 next byte is opcode", c_opc, 8'h87);
  endtask

  task automatic t_shift_read;
    int p0 = npay;
    send(8'h20); send(8'h34); send(8'h12); idle(3);
    chkeq("R2 0x20 count", c_cnt, 16'h1234);
    chkeq("R2 0x20 nparam", c_np, 2);
    send(8'h84); idle(3);
    chkeq("R3 no payload for read", npay - p0, 0);
    chkeq("R3 read then opcode", c_opc, 8'h84);
  endtask

  task automatic t_bitmode;
    send(8'h13); send(8'h05); send(8'hAA); idle(3);
    chkeq("R4 0x13 nparam", c_np, 2);
    chkeq("R4 0x13 count", c_cnt, 16'h0005);
    send(8'h22); send(8'h07); idle(3);
    chkeq("R4 0x22 nparam", c_np, 1);
    chkeq("R4 0x22 count", c_cnt, 16'h0007);
    send(8'h4B); send(8'h01); send(8'h03); idle(3);
    chkeq("R4 0x4B nparam", c_np, 2);
  endtask

  task automatic t_invalid;
    int c0 = ncmd;
    int e0 = nerr;
    send(8'h9F); idle(3);
    chkeq("R8 strobe count", nerr - e0, 1);
    chkeq("R8 err byte", e_byte, 8'h9F);
    chkeq("R8 no command", ncmd - c0, 0);
    send(8'h00); idle(3);
    chkeq("R8 0x00 err byte", e_byte, 8'h00);
    send(8'h8E); send(8'h09); idle(3);
    chkeq("R8 resume opcode", c_opc, 8'h8E);
    chkeq("R8 resume arg", c_arg, 24'h000009);
  endtask

  task automatic t_split;
    send(8'h82); idle(10);
    send(8'h3C); idle(7);
    send(8'hF0); idle(3);
    chkeq("R9 split opcode", c_opc, 8'h82);
    chkeq("R9 split arg", c_arg, 24'h00F03C);
  endtask

  task automatic t_hdr_stall;
    int c0 = ncmd;
    cmd_ready = 1'b0;
    send(8'h80); send(8'h5A);
    send(8'hC3);
    idle(4);
    chkeq("R10 held valid", cmd_valid, 1);
    chkeq("R10 in_ready low", in_ready, 0);
    chkeq("R10 held arg", cmd_arg, 24'h00C35A);
    cmd_ready = 1'b1; idle(3);
    chkeq("R10 one command", ncmd - c0, 1);
    chkeq("R10 arg after release", c_arg, 24'h00C35A);
  endtask

  task automatic t_pay_stall;
    int p0 = npay;
    send(8'h11); send(8'h01); send(8'h00); idle(2);
    pay_ready = 1'b0;
    in_valid = 1'b1; in_data = 8'hD1;
    idle(3);
    chkeq("R11 in_ready follows pay_ready", in_ready, 0);
    chkeq("R11 pay_valid mirrors in_valid", pay_valid, 1);
    chkeq("R11 pay_data mirrors in_data", pay_data, 8'hD1);
    pay_ready = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
    send(8'hD2); idle(2);
    chkeq("R11 stalled payload count", npay - p0, 2);
    chkeq("R11 stalled payload byte", pbuf[p0+1], 8'hD2);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_ctrl;
    t_port;
    t_bus;
    t_shift_write;
    t_shift_read;
    t_bitmode;
    t_invalid;
    t_split;
    t_hdr_stall;
    t_pay_stall;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule